// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Address Translation Buffer

This block caches virtual-to-physical page translations for a core that uses 8 KiB pages. Each lookup presents a virtual address together with two flags that say whether the access is an instruction fetch or a store. A lookup with neither flag set is a load. The lookup resolves in the same cycle and returns a hit flag and the physical address. When the lookup misses, the block raises a miss indication that carries the address and the access kind, so an external walker can fetch the translation.

The walker answers through a refill port. A refill writes the physical page base into one data array that all access kinds share. It also writes the tag for the one access kind named in the refill. The fetch, load and store kinds each keep their own tag array. A page therefore hits only for the kinds that were refilled for it. A page-table base register can be written at any time. The written value is page-aligned, and the write empties the whole buffer.

Top module: `split_tlb`

## Requirements
- R1: After reset every lookup misses and the page-table base output reads zero.
- R2: The buffer holds 256 entries and is direct-mapped. The entry index is virtual address bits [20:13]. Two pages that share these bits evict each other.
- R3: A lookup hits only when all virtual address bits above bit 12 equal those of the refilled page. This holds even for the page at the very top of the address space after a flush.
- R4: The access kind is picked by priority: fetch when the fetch flag is set, otherwise store when the store flag is set, otherwise load. The same rule applies to lookups and to refills. On the miss output the kind is encoded as load=0, store=1, fetch=2.
- R5: On a hit, the physical address is the stored page base with the low 13 bits of the virtual address. The low 13 bits of the refill base are ignored.
- R6: A valid lookup that misses raises the miss flag. The miss output carries the request address and the access kind.
- R7: A refill takes effect at the next clock edge. It makes only its own access kind hit for that page.
- R8: A refill leaves the other kinds' tags at its index unchanged when they hold the same page. Tags of the other kinds that hold a different page are invalidated.
- R9: A page-table base write stores the value with its low 13 bits cleared. From the next cycle on, every lookup misses until a new refill is made.
- R10: A refill in the same cycle as a page-table base write is discarded.
- R11: With no valid lookup, the hit flag and the miss flag are both low, and the physical address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_vaddr | input | 64 | Lookup virtual address |
| req_fetch | input | 1 | Lookup is an instruction fetch |
| req_store | input | 1 | Lookup is a store |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 64 | Translated physical address, zero unless hit |
| miss_valid | output | 1 | Lookup missed, translation needed |
| miss_vaddr | output | 64 | Address that missed |
| miss_kind | output | 2 | Access kind of the lookup (load=0, store=1, fetch=2) |
| refill_valid | input | 1 | Refill write request |
| refill_vaddr | input | 64 | Virtual page being refilled |
| refill_fetch | input | 1 | Refill is for the fetch kind |
| refill_store | input | 1 | Refill is for the store kind |
| refill_pbase | input | 64 | Physical page base for the refill |
| ptbr_we | input | 1 | Page-table base write enable, flushes buffer |
| ptbr_wdata | input | 64 | Page-table base write value |
| ptbr_q | output | 64 | Current page-table base |

## Verification
On every cycle, the assertions check the following: the idle outputs stay quiet; a hit keeps the page offset; the page-table base stays aligned; no lookup hits in the cycle after a flush; and a refill lands in its tag array and makes the same page and kind hit one cycle later. Some behaviours depend on a history of refills, so only the bench scenarios can show them. These are the eviction of aliasing pages, the invalidation or survival of the other kinds' tags, the priority when both flags are set, and a refill discarded by a simultaneous flush.

// File: rtl/tlb_pkg.sv
// Shared types and helpers for the split-tag translation buffer.
// Assumes three access kinds; the encoding is visible on the miss port.
package tlb_pkg;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2
    } acc_kind_e;

    localparam int unsigned NUM_KINDS = 3;

    // Priority pick of access kind: fetch over store over load.
    function automatic acc_kind_e pick_kind(input logic is_fetch, input logic is_store);
        if (is_fetch)      return KIND_FETCH;
        else if (is_store) return KIND_STORE;
        else               return KIND_LOAD;
    endfunction

endpackage

// File: rtl/tlb_tag_array.sv
// One tag array of the buffer, for a single access kind.
// It has two read ports: one for the lookup index and one for the refill index.
// It has one write port and one invalidate port. A flush marks every entry
// invalid in one cycle. The invalid code is all ones. A live tag always has a
// zero MSB, so no live tag can equal the invalid code.
// Assumes that wr_en and inv_en never target the same cycle.
module tlb_tag_array #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned TAG_W   = 52,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    input  logic [IDX_W-1:0] wr_idx,
    output logic [TAG_W-1:0] cmp_tag,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             inv_en
);
    localparam logic [TAG_W-1:0] TAG_INVALID = '1;

    logic [TAG_W-1:0] mem [ENTRIES];

    // Read ports, combinational.
    assign rd_tag  = mem[rd_idx];
    assign cmp_tag = mem[wr_idx];

    // Tag storage: reset/flush invalidates all, else write or invalidate one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < int'(ENTRIES); i++) mem[i] <= TAG_INVALID;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_tag;
        end else if (inv_en) begin
            mem[wr_idx] <= TAG_INVALID;
        end
    end

    assert_flush_invalidates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (mem[0] == TAG_INVALID && mem[ENTRIES-1] == TAG_INVALID));

    assert_write_lands_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (mem[$past(wr_idx)] == $past(wr_tag)));

    assert_inval_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !wr_en && !flush) |=> (mem[$past(wr_idx)] == TAG_INVALID));

endmodule

// File: rtl/tlb_data_array.sv
// The physical page base array that all access kinds share.
// It holds page numbers only. It has no reset, because the tag arrays alone
// decide validity.
module tlb_data_array #(
    parameter int unsigned ENTRIES = 256,
    parameter int unsigned PPN_W   = 51,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PPN_W-1:0] rd_ppn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PPN_W-1:0] wr_ppn
);
    logic [PPN_W-1:0] mem [ENTRIES];

    // Lookup read, combinational.
    assign rd_ppn = mem[rd_idx];

    // Refill write of the page base.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_ppn;
    end

endmodule

// File: rtl/tlb_ptbr_reg.sv
// Page-table base register. It stores the written value page-aligned.
// It flags a flush of the whole buffer in the cycle of the write.
module tlb_ptbr_reg #(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned OFF_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] wdata,
    output logic [ADDR_W-1:0] q,
    output logic              flush
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~((ADDR_W)'((64'd1 << OFF_W) - 64'd1));

    // Flush request follows the write strobe.
    assign flush = we;

    // Base register with page alignment on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata & ALIGN_MASK;
    end

    assert_ptbr_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q[OFF_W-1:0] == '0);

    assert_ptbr_takes_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q[ADDR_W-1:OFF_W] == $past(wdata[ADDR_W-1:OFF_W])));

endmodule

// File: rtl/split_tlb.sv
// Direct-mapped translation buffer with separate fetch, load and store tag
// arrays over one shared page-base array. The lookup is combinational. Refill
// and flush take effect at the next clock edge. A flush (page-table base write)
// takes precedence over a refill in the same cycle. A refill invalidates the
// other kinds' tags at its index when they hold a different page.
module split_tlb
    import tlb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 64,
    parameter int unsigned PAGE_SHIFT = 13,
    parameter int unsigned ENTRIES    = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic              req_fetch,
    input  logic              req_store,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              miss_valid,
    output logic [ADDR_W-1:0] miss_vaddr,
    output logic [1:0]        miss_kind,
    input  logic              refill_valid,
    input  logic [ADDR_W-1:0] refill_vaddr,
    input  logic              refill_fetch,
    input  logic              refill_store,
    input  logic [ADDR_W-1:0] refill_pbase,
    input  logic              ptbr_we,
    input  logic [ADDR_W-1:0] ptbr_wdata,
    output logic [ADDR_W-1:0] ptbr_q
);
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned VPN_W = ADDR_W - PAGE_SHIFT;
    localparam int unsigned TAG_W = VPN_W + 1;

    acc_kind_e        lk_kind, rf_kind;
    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic [TAG_W-1:0] lk_tag, rf_tag;
    logic [TAG_W-1:0] lk_tags  [NUM_KINDS];
    logic [TAG_W-1:0] cmp_tags [NUM_KINDS];
    logic [NUM_KINDS-1:0] wr_en, inv_en;
    logic [VPN_W-1:0] lk_ppn;
    logic             flush, rf_go, hit_raw;

    // Decode the index, the expected tag and the kind of the lookup and the refill.
    always_comb begin
        lk_kind = pick_kind(req_fetch, req_store);
        rf_kind = pick_kind(refill_fetch, refill_store);
        lk_idx  = req_vaddr[PAGE_SHIFT +: IDX_W];
        rf_idx  = refill_vaddr[PAGE_SHIFT +: IDX_W];
        lk_tag  = {1'b0, req_vaddr[ADDR_W-1:PAGE_SHIFT]};
        rf_tag  = {1'b0, refill_vaddr[ADDR_W-1:PAGE_SHIFT]};
        rf_go   = refill_valid && !flush;
    end

    tlb_ptbr_reg #(.ADDR_W(ADDR_W), .OFF_W(PAGE_SHIFT)) u_ptbr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ptbr_we),
        .wdata (ptbr_wdata),
        .q     (ptbr_q),
        .flush (flush)
    );

    // One tag array per access kind.
    for (genvar k = 0; k < int'(NUM_KINDS); k++) begin : g_kind
        // Write the kind that missed; drop the other kinds if they hold a different page.
        always_comb begin
            wr_en[k]  = rf_go && (rf_kind == acc_kind_e'(k));
            inv_en[k] = rf_go && (rf_kind != acc_kind_e'(k)) && (cmp_tags[k] != rf_tag);
        end

        tlb_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
            .clk     (clk),
            .rst_n   (rst_n),
            .flush   (flush),
            .rd_idx  (lk_idx),
            .rd_tag  (lk_tags[k]),
            .wr_idx  (rf_idx),
            .cmp_tag (cmp_tags[k]),
            .wr_en   (wr_en[k]),
            .wr_tag  (rf_tag),
            .inv_en  (inv_en[k])
        );
    end

    tlb_data_array #(.ENTRIES(ENTRIES), .PPN_W(VPN_W)) u_data (
        .clk    (clk),
        .rd_idx (lk_idx),
        .rd_ppn (lk_ppn),
        .wr_en  (rf_go),
        .wr_idx (rf_idx),
        .wr_ppn (refill_pbase[ADDR_W-1:PAGE_SHIFT])
    );

    // Compare the selected kind's tag and form the response and miss outputs.
    always_comb begin
        hit_raw    = (lk_tags[lk_kind] == lk_tag);
        rsp_hit    = req_valid && hit_raw;
        rsp_paddr  = rsp_hit ? {lk_ppn, req_vaddr[PAGE_SHIFT-1:0]} : '0;
        miss_valid = req_valid && !hit_raw;
        miss_vaddr = req_vaddr;
        miss_kind  = lk_kind;
    end

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!rsp_hit && !miss_valid && rsp_paddr == '0));

    assert_offset_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_paddr[PAGE_SHIFT-1:0] == req_vaddr[PAGE_SHIFT-1:0]));

    assert_no_hit_after_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ptbr_we |=> !rsp_hit);

    assert_fetch_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fetch) |-> (miss_kind == KIND_FETCH));

    assert_refill_then_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid && !ptbr_we) |=>
            (!(req_valid && lk_kind == $past(rf_kind) &&
               req_vaddr[ADDR_W-1:PAGE_SHIFT] == $past(refill_vaddr[ADDR_W-1:PAGE_SHIFT]))
             || rsp_hit));

    assert_refill_after_flush_dropped_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (refill_valid && ptbr_we) |=> !rsp_hit);

endmodule

// File: tb/split_tlb_tb.sv
// Scoreboard bench: driver tasks push the expected response, a monitor pops it
// and compares it with the outputs a quarter period after each falling edge.
module split_tlb_tb;
    localparam int unsigned AW = 64;
    localparam int unsigned PS = 13;
    localparam int unsigned NE = 256;
    localparam logic [AW-PS:0] INV = '1;

    typedef struct {
        logic        hit;
        logic [63:0] paddr;
        logic        miss;
        logic [1:0]  kind;
        logic [63:0] vaddr;
        logic        active;
        logic [63:0] ptbr;
        string       tag;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_fetch = 0, req_store = 0;
    logic [63:0] req_vaddr = '0;
    logic rsp_hit, miss_valid;
    logic [63:0] rsp_paddr, miss_vaddr, ptbr_q;
    logic [1:0] miss_kind;
    logic refill_valid = 0, refill_fetch = 0, refill_store = 0, ptbr_we = 0;
    logic [63:0] refill_vaddr = '0, refill_pbase = '0, ptbr_wdata = '0;

    int checks = 0, failures = 0;
    exp_t q[$];
    logic [AW-PS:0]  mtag [3][NE];
    logic [AW-PS-1:0] mdata [NE];
    logic [63:0] mptbr;

    always #10 clk = ~clk;

    split_tlb u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_fetch(req_fetch), .req_store(req_store),
        .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .miss_valid(miss_valid), .miss_vaddr(miss_vaddr), .miss_kind(miss_kind),
        .refill_valid(refill_valid), .refill_vaddr(refill_vaddr), .refill_fetch(refill_fetch),
        .refill_store(refill_store), .refill_pbase(refill_pbase),
        .ptbr_we(ptbr_we), .ptbr_wdata(ptbr_wdata), .ptbr_q(ptbr_q)
    );

    function automatic int kind_of(input logic f, input logic s);
        return f ? 2 : (s ? 1 : 0);
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_flush();
        for (int k = 0; k < 3; k++)
            for (int i = 0; i < int'(NE); i++) mtag[k][i] = INV;
    endtask

    task automatic clear_inputs();
        req_valid = 0; refill_valid = 0; ptbr_we = 0;
        req_fetch = 0; req_store = 0; refill_fetch = 0; refill_store = 0;
    endtask

    task automatic push_idle(input string tag);
        exp_t e;
        e.hit = 0; e.paddr = '0; e.miss = 0; e.kind = 0; e.vaddr = '0;
        e.active = 0; e.ptbr = mptbr; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic lookup(input logic [63:0] va, input logic f, input logic s, input string tag);
        exp_t e;
        int k, idx;
        @(negedge clk);
        clear_inputs();
        req_valid = 1; req_vaddr = va; req_fetch = f; req_store = s;
        k = kind_of(f, s);
        idx = int'(va[PS +: 8]);
        e.hit    = (mtag[k][idx] == {1'b0, va[63:PS]});
        e.paddr  = e.hit ? {mdata[idx], va[PS-1:0]} : 64'd0;
        e.miss   = !e.hit;
        e.kind   = 2'(k);
        e.vaddr  = va;
        e.active = 1;
        e.ptbr   = mptbr;
        e.tag    = tag;
        q.push_back(e);
    endtask

    task automatic refill(input logic [63:0] va, input logic f, input logic s, input logic [63:0] pb,
                          input logic with_flush, input logic [63:0] pt);
        int k, idx;
        logic [AW-PS:0] nt;
        @(negedge clk);
        clear_inputs();
        refill_valid = 1; refill_vaddr = va; refill_fetch = f; refill_store = s; refill_pbase = pb;
        ptbr_we = with_flush; ptbr_wdata = pt;
        push_idle("R11");
        if (with_flush) begin
            model_flush();
            mptbr = pt & ~64'h1FFF;
        end else begin
            k = kind_of(f, s);
            idx = int'(va[PS +: 8]);
            nt = {1'b0, va[63:PS]};
            for (int j = 0; j < 3; j++)
                if (j != k && mtag[j][idx] != nt) mtag[j][idx] = INV;
            mtag[k][idx] = nt;
            mdata[idx] = pb[63:PS];
        end
    endtask

    task automatic write_ptbr(input logic [63:0] v);
        @(negedge clk);
        clear_inputs();
        ptbr_we = 1; ptbr_wdata = v;
        push_idle("R11");
        model_flush();
        mptbr = v & ~64'h1FFF;
    endtask

    // Monitor: compare the outputs against the oldest expected item.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk(rsp_hit == e.hit, {e.tag, " hit"}, 64'(rsp_hit), 64'(e.hit));
                chk(rsp_paddr == e.paddr, {e.tag, " paddr"}, rsp_paddr, e.paddr);
                chk(miss_valid == e.miss, {e.tag, " miss"}, 64'(miss_valid), 64'(e.miss));
                if (e.active) begin
                    chk(miss_kind == e.kind, {e.tag, " kind"}, 64'(miss_kind), 64'(e.kind));
                    chk(miss_vaddr == e.vaddr, {e.tag, " miss_vaddr"}, miss_vaddr, e.vaddr);
                end
                chk(ptbr_q == e.ptbr, {e.tag, " ptbr"}, ptbr_q, e.ptbr);
            end
        end
    end

    localparam logic [63:0] PA  = 64'h0000_1234_5678_A000;
    localparam logic [63:0] PB  = 64'h0000_4234_5678_A000;
    localparam logic [63:0] PC  = 64'h0000_0000_0040_6000;
    localparam logic [63:0] P0  = 64'h0000_0000_0000_0000;
    localparam logic [63:0] P255 = 64'h0000_0000_001F_E000;
    localparam logic [63:0] TOP = 64'hFFFF_FFFF_FFFF_E000;

    initial begin
        model_flush();
        mptbr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: quiet, empty and zero base after reset
        @(negedge clk); clear_inputs(); push_idle("R1");
        lookup(64'h2000, 0, 0, "R1");
        lookup(64'h2000, 1, 0, "R1");
        lookup(64'h2000, 0, 1, "R6");
        // R7: load refill hits only for loads; R5 base low bits ignored
        refill(PA, 0, 0, 64'h0000_0000_8000_1FFF, 0, 0);
        lookup(PA | 64'h123, 0, 0, "R5");
        lookup(PA, 1, 0, "R7");
        lookup(PA | 64'h1FFF, 0, 1, "R7");
        // R8: same page for store keeps load tag
        refill(PA, 0, 1, 64'h0000_0000_8000_0000, 0, 0);
        lookup(PA | 64'h44, 0, 0, "R8");
        lookup(PA | 64'h48, 0, 1, "R8");
        // R2/R3/R8: alias page at same index evicts other kinds
        refill(PB, 1, 0, 64'h0000_0000_9000_0000, 0, 0);
        lookup(PB | 64'h10, 1, 0, "R2");
        lookup(PA, 0, 0, "R8");
        lookup(PA, 0, 1, "R8");
        lookup(PB, 0, 0, "R3");
        // R4: both flags set selects fetch tags
        refill(PC, 0, 1, 64'h0000_0001_0000_0000, 0, 0);
        lookup(PC, 1, 1, "R4");
        lookup(PC | 64'h8, 0, 1, "R4");
        // R2: index extremes are independent
        refill(P0, 0, 0, 64'h0000_0000_0AAA_A000, 0, 0);
        refill(P255, 0, 0, 64'h0000_0000_0BBB_B000, 0, 0);
        lookup(P0 | 64'h1, 0, 0, "R2");
        lookup(P255 | 64'h2, 0, 0, "R2");
        lookup(P0 | 64'h0020_0000, 0, 0, "R3");
        // R11: idle cycle
        @(negedge clk); clear_inputs(); push_idle("R11");
        // R9: base write aligns and flushes
        write_ptbr(64'h0000_ABCD_1FFF);
        lookup(P0, 0, 0, "R9");
        lookup(PC, 0, 1, "R9");
        lookup(TOP | 64'h123, 0, 0, "R3");
        // R10: refill discarded when flushed in the same cycle
        refill(PA, 0, 0, 64'h0000_0000_7000_0000, 1, 64'h0000_0000_0004_2001);
        lookup(PA, 0, 0, "R10");
        // R3: top page hits once refilled
        refill(TOP, 1, 0, 64'h0000_0000_0055_6000, 0, 0);
        lookup(TOP | 64'h1FFE, 1, 0, "R3");
        @(negedge clk); clear_inputs(); push_idle("R11");
        @(negedge clk); @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 64'd1, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule